// File: doc/BRIEF.md
# SMBus Clock-Output Control Register Slave

This block is the serial control port of a multi-output differential clock buffer. It listens on the two-wire SMBus lines and accepts Byte Write, Byte Read, Block Write and Block Read transactions. It holds the registers that gate each output pair, switch off the two feedback clocks, and choose the input threshold. The sampled bus lines run through a synchroniser on the system clock. The block pulls SDA low through an open-drain enable and never drives it high.

Two strap pins adapt the slave to the board:
- `addr_sel` picks one of two 7-bit bus addresses.
- `cs_strap` picks which two-bit pattern in the command byte counts as a match. Several buffers can then share one bus address.

Only offsets 22 and 23 hold state. Every other offset in the 24-byte map reads as zero and ignores writes. After reset every output pair is active, both feedback clocks are enabled and the threshold code is at its normal setting.

Top module: `clkctl_smb_slave`

## Requirements
- R1: After reset, `pair_en` is all ones, `fb_dis_a` and `fb_dis_b` are 0 and `thresh` is 00. This means offset 22 holds 0x0F and offset 23 holds 0xFF.
- R2: The slave acknowledges its address in either direction:
  - with `addr_sel` high, address 7'b1101001 (bytes 0xD2 for write, 0xD3 for read);
  - with `addr_sel` low, address 7'b1101110 (bytes 0xDC for write, 0xDD for read).
  Any other address gets a NACK, and the rest of that transaction has no effect.
- R3: The command byte is checked against `cs_strap`:
  - bits 6:5 must be 01 when `cs_strap` is low and 10 when it is high;
  - a mismatching command gets a NACK, and the bytes after it have no effect.
- R4: A Byte Write uses a command with bit 7 = 1, and command bits 4:0 give the target offset. The written value reaches the outputs as follows:
  - offset 22: bits 7:6 drive `thresh`, bit 5 drives `fb_dis_a`, bit 4 drives `fb_dis_b`, and bits 3:0 drive `pair_en[11:8]`;
  - offset 23: bits 7:0 drive `pair_en[7:0]`.
- R5: A Block Write uses a command with bit 7 = 0 and bits 4:0 = 0. The master sends one byte-count byte, which is ignored. Data bytes then land at offsets 0, 1, 2 and upward.
- R6: A Byte Read works in three steps. The master writes the command, sends a repeated start, and then sends the read address. The slave then returns the byte at the commanded offset, most significant bit first.
- R7: A Block Read returns the byte count 24 first. It then returns offsets 0 upward, and after offset 23 it wraps to offset 0.
- R8: Offsets other than 22 and 23 accept writes with an ACK, but the outputs do not change. Reads of these offsets return 0x00.
- R9: A start or stop condition in the middle of a byte abandons that byte and leaves the registers unchanged. A start condition always re-arms address reception.
- R10: While it is addressed by a matching write, the slave acknowledges every byte: address, command, byte count and data. SDA changes only while SCL is low.
- R11: After the master NACKs a read byte, the slave releases SDA until the next start condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SMBus clock line |
| sda_i | input | 1 | SMBus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| addr_sel | input | 1 | Address-select strap |
| cs_strap | input | 1 | Command chip-select strap |
| pair_en | output | 12 | Per-pair output enable, 1 = active |
| fb_dis_a | output | 1 | 1 disables feedback output A |
| fb_dis_b | output | 1 | 1 disables feedback output B |
| thresh | output | 2 | Input threshold code, 00 = normal |

## Verification
The bench builds the block with its default parameters:
- a two-flop synchroniser;
- a 24-byte map;
- live registers at offsets 22 and 23.

With these values a block transfer walks the full map, crosses both live bytes among the reserved ones, and reaches the wrap back to offset 0 within a few hundred bit times. Both settings of each strap are exercised, so the two addresses and the two command match patterns each get accepted and rejected. The reference model tracks only the two live bytes. Its expected outputs are compared once per bit clock, so a write that lands late or at the wrong offset shows up within one bit.

// File: rtl/smbclk_pkg.sv
package smbclk_pkg;

    localparam int BYTE_W = 8;
    localparam int PAIRS  = 12;

    localparam logic [6:0] ADDR_SEL_HI = 7'b1101001;
    localparam logic [6:0] ADDR_SEL_LO = 7'b1101110;

    localparam logic [BYTE_W-1:0] CTL_A_RST = 8'h0F;
    localparam logic [BYTE_W-1:0] CTL_B_RST = 8'hFF;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_RX_ACK,
        PH_TX,
        PH_TX_ACK,
        PH_HOLD
    } phase_t;

    typedef enum logic [1:0] {
        FLD_ADDR,
        FLD_CMD,
        FLD_COUNT,
        FLD_DATA
    } field_t;

    typedef struct packed {
        logic [1:0]       thresh;
        logic             fb_dis_a;
        logic             fb_dis_b;
        logic [PAIRS-1:0] pair_en;
    } ctl_t;

    function automatic logic [6:0] dev_addr(input logic sel);
        return sel ? ADDR_SEL_HI : ADDR_SEL_LO;
    endfunction

    function automatic logic cmd_hits(input logic [BYTE_W-1:0] cmd, input logic cs);
        return cmd[6:5] == (cs ? 2'b10 : 2'b01);
    endfunction

    function automatic ctl_t unpack_ctl(input logic [BYTE_W-1:0] a,
                                        input logic [BYTE_W-1:0] b);
        ctl_t c;
        c.thresh   = a[7:6];
        c.fb_dis_a = a[5];
        c.fb_dis_b = a[4];
        c.pair_en  = {a[3:0], b};
        return c;
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_q, sda_q;
    logic              scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
            scl_d <= scl_q[STAGES-1];
            sda_d <= sda_q[STAGES-1];
        end
    end

    always_comb begin
        scl_s     = scl_q[STAGES-1];
        sda_s     = sda_q[STAGES-1];
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/smb_xact.sv
module smb_xact
    import smbclk_pkg::*;
#(
    parameter int NBYTES = 24,
    localparam int PW = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              addr_sel,
    input  logic              cs_strap,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [PW-1:0]     wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic [PW-1:0]     ptr
);
    phase_t            phase;
    field_t            field;
    logic [BYTE_W-1:0] shreg;
    logic [3:0]        bitcnt;
    logic              cmd_ok, blk, reading, send_count, ack_bit;
    logic [BYTE_W-1:0] tx_byte;

    function automatic logic [PW-1:0] next_ptr(input logic [PW-1:0] p);
        return (p == PW'(NBYTES - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb tx_byte = send_count ? BYTE_W'(NBYTES) : rd_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            field      <= FLD_ADDR;
            shreg      <= '0;
            bitcnt     <= '0;
            cmd_ok     <= 1'b0;
            blk        <= 1'b0;
            reading    <= 1'b0;
            send_count <= 1'b0;
            ack_bit    <= 1'b1;
            sda_oe     <= 1'b0;
            wr_en      <= 1'b0;
            wr_idx     <= '0;
            wr_data    <= '0;
            ptr        <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                phase  <= PH_RX;
                field  <= FLD_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                phase  <= PH_IDLE;
                cmd_ok <= 1'b0;
                sda_oe <= 1'b0;
            end else begin
                unique case (phase)
                    PH_RX: begin
                        if (scl_rise && bitcnt < 4'd8) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            unique case (field)
                                FLD_ADDR: begin
                                    if (shreg[7:1] == dev_addr(addr_sel) && (!shreg[0] || cmd_ok)) begin
                                        sda_oe  <= 1'b1;
                                        phase   <= PH_RX_ACK;
                                        reading <= shreg[0];
                                    end else begin
                                        phase <= PH_HOLD;
                                    end
                                end
                                FLD_CMD: begin
                                    if (cmd_hits(shreg, cs_strap)) begin
                                        sda_oe     <= 1'b1;
                                        phase      <= PH_RX_ACK;
                                        cmd_ok     <= 1'b1;
                                        blk        <= ~shreg[7];
                                        send_count <= ~shreg[7];
                                        ptr        <= shreg[7] ? PW'(shreg[4:0]) : '0;
                                    end else begin
                                        cmd_ok <= 1'b0;
                                        phase  <= PH_HOLD;
                                    end
                                end
                                FLD_COUNT: begin
                                    sda_oe <= 1'b1;
                                    phase  <= PH_RX_ACK;
                                end
                                default: begin
                                    sda_oe  <= 1'b1;
                                    phase   <= PH_RX_ACK;
                                    wr_en   <= 1'b1;
                                    wr_idx  <= ptr;
                                    wr_data <= shreg;
                                    ptr     <= next_ptr(ptr);
                                end
                            endcase
                        end
                    end
                    PH_RX_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            if (field == FLD_ADDR && reading) begin
                                phase  <= PH_TX;
                                shreg  <= tx_byte;
                                sda_oe <= ~tx_byte[7];
                                bitcnt <= 4'd1;
                                if (send_count) send_count <= 1'b0;
                                else            ptr <= next_ptr(ptr);
                            end else begin
                                phase <= PH_RX;
                                unique case (field)
                                    FLD_ADDR:  field <= FLD_CMD;
                                    FLD_CMD:   field <= blk ? FLD_COUNT : FLD_DATA;
                                    default:   field <= FLD_DATA;
                                endcase
                            end
                        end
                    end
                    PH_TX: begin
                        if (scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                phase  <= PH_TX_ACK;
                                bitcnt <= '0;
                            end else begin
                                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~shreg[6];
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                    PH_TX_ACK: begin
                        if (scl_rise) begin
                            ack_bit <= sda_s;
                        end else if (scl_fall) begin
                            if (!ack_bit) begin
                                phase  <= PH_TX;
                                shreg  <= tx_byte;
                                sda_oe <= ~tx_byte[7];
                                bitcnt <= 4'd1;
                                if (send_count) send_count <= 1'b0;
                                else            ptr <= next_ptr(ptr);
                            end else begin
                                phase <= PH_HOLD;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R10
    sda_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_s);

    // R11
    hold_released_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HOLD) |-> !sda_oe);

    // R9
    start_no_commit_chk: assert property (@(posedge clk) disable iff (rst)
        start_det |=> !wr_en);

    // R2
    wr_only_data_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(field) == FLD_DATA);
endmodule

// File: rtl/clkctl_regs.sv
module clkctl_regs
    import smbclk_pkg::*;
#(
    parameter int NBYTES = 24,
    parameter int IDX_A  = 22,
    parameter int IDX_B  = 23,
    localparam int PW = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PW-1:0]     wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [PW-1:0]     rd_idx,
    output logic [BYTE_W-1:0] rd_data,
    output ctl_t              ctl
);
    logic [BYTE_W-1:0] r_a, r_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            r_a <= CTL_A_RST;
            r_b <= CTL_B_RST;
        end else if (wr_en) begin
            if (wr_idx == PW'(IDX_A)) r_a <= wr_data;
            if (wr_idx == PW'(IDX_B)) r_b <= wr_data;
        end
    end

    always_comb begin
        if (rd_idx == PW'(IDX_A))      rd_data = r_a;
        else if (rd_idx == PW'(IDX_B)) rd_data = r_b;
        else                           rd_data = '0;
        ctl = unpack_ctl(r_a, r_b);
    end

    // R8
    rsvd_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx != PW'(IDX_A) && wr_idx != PW'(IDX_B)) |=> $stable(ctl));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ctl));
endmodule

// File: rtl/clkctl_smb_slave.sv
module clkctl_smb_slave
    import smbclk_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int NBYTES      = 24,
    parameter int IDX_A       = 22,
    parameter int IDX_B       = 23
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic             addr_sel,
    input  logic             cs_strap,
    output logic [PAIRS-1:0] pair_en,
    output logic             fb_dis_a,
    output logic             fb_dis_b,
    output logic [1:0]       thresh
);
    localparam int PW = $clog2(NBYTES);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en;
    logic [PW-1:0]     wr_idx, ptr;
    logic [BYTE_W-1:0] wr_data, rd_data;
    ctl_t              ctl;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    smb_xact #(.NBYTES(NBYTES)) u_xact (
        .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .addr_sel(addr_sel), .cs_strap(cs_strap), .rd_data(rd_data),
        .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .ptr(ptr)
    );

    clkctl_regs #(.NBYTES(NBYTES), .IDX_A(IDX_A), .IDX_B(IDX_B)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(ptr), .rd_data(rd_data), .ctl(ctl)
    );

    always_comb begin
        pair_en  = ctl.pair_en;
        fb_dis_a = ctl.fb_dis_a;
        fb_dis_b = ctl.fb_dis_b;
        thresh   = ctl.thresh;
    end
endmodule

// File: tb/clkctl_smb_slave_tb.sv
module clkctl_smb_slave_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic        addr_sel = 1'b1;
    logic        cs_strap = 1'b0;
    logic        sda_oe, fb_dis_a, fb_dis_b;
    logic [11:0] pair_en;
    logic [1:0]  thresh;
    logic        sda_line;

    int    vectors = 0;
    int    miscompares = 0;
    string cur_req = "R1";
    logic [7:0] m22 = 8'h0F;
    logic [7:0] m23 = 8'hFF;
    logic [7:0] rd_q[$];

    assign sda_line = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    clkctl_smb_slave u_dut (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .addr_sel(addr_sel), .cs_strap(cs_strap), .pair_en(pair_en),
        .fb_dis_a(fb_dis_a), .fb_dis_b(fb_dis_b), .thresh(thresh)
    );

    function automatic logic [7:0] model_rd(input int idx);
        if (idx == 22) return m22;
        if (idx == 23) return m23;
        return 8'h00;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic compare_outputs();
        chk(cur_req, {thresh, fb_dis_a, fb_dis_b, pair_en},
            {m22[7:6], m22[5], m22[4], m22[3:0], m23});
    endtask

    task automatic bit_cycle(input logic drive, output logic seen);
        @(negedge clk) scl = 1'b0;
        repeat (3) @(negedge clk);
        sda_m = drive;
        repeat (3) @(negedge clk);
        compare_outputs();
        repeat (2) @(negedge clk);
        scl = 1'b1;
        repeat (4) @(negedge clk);
        seen = sda_line;
        repeat (4) @(negedge clk);
    endtask

    task automatic start_cond();
        @(negedge clk) scl = 1'b0;
        repeat (4) @(negedge clk);
        sda_m = 1'b1;
        repeat (4) @(negedge clk);
        scl = 1'b1;
        repeat (4) @(negedge clk);
        sda_m = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic stop_cond();
        @(negedge clk) scl = 1'b0;
        repeat (4) @(negedge clk);
        sda_m = 1'b0;
        repeat (4) @(negedge clk);
        scl = 1'b1;
        repeat (4) @(negedge clk);
        sda_m = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic wr_byte(input logic [7:0] b, input int upd, input logic exp_ack, input string req);
        logic s;
        cur_req = req;
        for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
        if (upd == 22) m22 = b;
        if (upd == 23) m23 = b;
        bit_cycle(1'b1, s);
        chk(req, !s, exp_ack);
    endtask

    task automatic rd_byte(input logic nack, input logic [7:0] exp, input string req);
        logic s;
        logic [7:0] b;
        cur_req = req;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            bit_cycle(1'b1, s);
            b = {b[6:0], s};
        end
        bit_cycle(nack, s);
        chk(req, b, exp);
        if (nack) chk("R11", sda_oe, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic s;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1", pair_en, 12'hFFF);
        chk("R1", {fb_dis_a, fb_dis_b, thresh}, 4'b0000);
        chk("R1", sda_oe, 1'b0);

        // R4 / R10 byte writes, cs_strap low, addr_sel high
        start_cond();
        wr_byte(8'hD2, -1, 1'b1, "R10");
        wr_byte(8'hB6, -1, 1'b1, "R10");
        wr_byte(8'hE5, 22, 1'b1, "R4");
        stop_cond();
        chk("R4", {thresh, fb_dis_a, fb_dis_b, pair_en[11:8]}, {2'b11, 1'b1, 1'b0, 4'h5});
        start_cond();
        wr_byte(8'hD2, -1, 1'b1, "R10");
        wr_byte(8'hB7, -1, 1'b1, "R10");
        wr_byte(8'h3C, 23, 1'b1, "R4");
        stop_cond();
        chk("R4", pair_en, 12'h53C);

        // R6 byte read of offset 22
        start_cond();
        wr_byte(8'hD2, -1, 1'b1, "R6");
        wr_byte(8'hB6, -1, 1'b1, "R6");
        start_cond();
        wr_byte(8'hD3, -1, 1'b1, "R6");
        rd_byte(1'b1, 8'hE5, "R6");
        stop_cond();

        // R2 wrong address ignored, then the other strap setting
        start_cond();
        wr_byte(8'hDC, -1, 1'b0, "R2");
        wr_byte(8'hB6, -1, 1'b0, "R2");
        wr_byte(8'h00, -1, 1'b0, "R2");
        stop_cond();
        addr_sel = 1'b0;
        start_cond();
        wr_byte(8'hDC, -1, 1'b1, "R2");
        wr_byte(8'hB7, -1, 1'b1, "R2");
        wr_byte(8'h5A, 23, 1'b1, "R2");
        stop_cond();
        start_cond();
        wr_byte(8'hD2, -1, 1'b0, "R2");
        stop_cond();
        addr_sel = 1'b1;

        // R3 command match field against cs_strap
        start_cond();
        wr_byte(8'hD2, -1, 1'b1, "R3");
        wr_byte(8'hD6, -1, 1'b0, "R3");
        wr_byte(8'h00, -1, 1'b0, "R3");
        stop_cond();
        cs_strap = 1'b1;
        start_cond();
        wr_byte(8'hD2, -1, 1'b1, "R3");
        wr_byte(8'hD6, -1, 1'b1, "R3");
        wr_byte(8'h81, 22, 1'b1, "R3");
        stop_cond();

        // R8 reserved offset 5
        start_cond();
        wr_byte(8'hD2, -1, 1'b1, "R8");
        wr_byte(8'hC5, -1, 1'b1, "R8");
        wr_byte(8'hFF, 5, 1'b1, "R8");
        stop_cond();
        start_cond();
        wr_byte(8'hD2, -1, 1'b1, "R8");
        wr_byte(8'hC5, -1, 1'b1, "R8");
        start_cond();
        wr_byte(8'hD3, -1, 1'b1, "R8");
        rd_byte(1'b1, 8'h00, "R8");
        stop_cond();

        // R5 block write over the whole map
        start_cond();
        wr_byte(8'hD2, -1, 1'b1, "R5");
        wr_byte(8'h40, -1, 1'b1, "R5");
        wr_byte(8'd24, -1, 1'b1, "R5");
        for (int i = 0; i < 24; i++)
            wr_byte((i == 22) ? 8'h7A : (i == 23) ? 8'hC3 : 8'hFF, i, 1'b1, "R5");
        stop_cond();
        chk("R5", {thresh, fb_dis_a, fb_dis_b, pair_en}, {2'b01, 1'b1, 1'b1, 12'hAC3});

        // R7 block read with wrap
        rd_q.delete();
        rd_q.push_back(8'd24);
        for (int i = 0; i < 26; i++) rd_q.push_back(model_rd(i % 24));
        start_cond();
        wr_byte(8'hD2, -1, 1'b1, "R7");
        wr_byte(8'h40, -1, 1'b1, "R7");
        start_cond();
        wr_byte(8'hD3, -1, 1'b1, "R7");
        while (rd_q.size() > 0) begin
            logic [7:0] e;
            e = rd_q.pop_front();
            rd_byte(rd_q.size() == 0, e, "R7");
        end
        stop_cond();

        // R9 start and stop in mid-byte
        start_cond();
        wr_byte(8'hD2, -1, 1'b1, "R9");
        wr_byte(8'hD6, -1, 1'b1, "R9");
        cur_req = "R9";
        for (int i = 0; i < 4; i++) bit_cycle(1'b0, s);
        start_cond();
        wr_byte(8'hD2, -1, 1'b1, "R9");
        wr_byte(8'hD6, -1, 1'b1, "R9");
        cur_req = "R9";
        for (int i = 0; i < 3; i++) bit_cycle(1'b0, s);
        stop_cond();
        repeat (8) @(negedge clk);
        chk("R9", {thresh, fb_dis_a, fb_dis_b, pair_en}, {2'b01, 1'b1, 1'b1, 12'hAC3});
        chk("R9", sda_oe, 1'b0);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule